// File: doc/BRIEF.md
# Microstep Translator Indexer

This block turns step and direction pulses into a phase position for a two-phase bipolar stepper motor. It keeps a 7-bit index into one electrical cycle of 128 positions. Each rising edge on the step input moves that index by a stride chosen by the three-bit resolution select, forward or backward according to the direction input. From the index it produces a current setpoint for each winding: a percentage magnitude from 0 to 100 and a polarity bit. Winding 1 follows the cosine of the electrical angle and winding 2 follows the sine.

The step input is asynchronous to the system clock. A two-flop synchronizer and an edge detector turn each low-to-high transition into a one-cycle advance pulse. The resolution select and the direction input are sampled only on that pulse. The resolution sampled there sets both the stride of that move and the setpoint shaping used until the next move. Both magnitudes come from one quarter-wave table, read a quarter cycle apart.

Two paths force the translator back to its home position: a held active-low translator reset, and a home request from the protection logic. The home position is the 45 degree point, which every resolution can reach. The analog converter, the current comparators and the power stages are outside the block.

Top module: `ustep_translator`

## Requirements
- R1: After the system reset the index is 16 (the 45 degree point) and the latched resolution is 000. Both windings therefore read magnitude 100 with polarity bit 0.
- R2: The latched resolution maps to a stride as follows: 000 → 32 (full step, full torque), 001 → 16 (half step, full torque), 010 → 2 (1/16), 011 → 1 (1/32), 100 → 32 (full step, sine), 101 → 16 (half step, sine), 110 → 8 (1/4) and 111 → 4 (1/8).
- R3: Each low-to-high transition of the step input moves the index by exactly one stride. A step input held high causes no further moves.
- R4: With the direction input at 0 the index increases by the stride; with it at 1 the index decreases by the stride.
- R5: A change on the resolution or direction inputs with no step edge leaves the setpoint outputs unchanged. The new values apply from the next step edge.
- R6: The index wraps modulo 128 in both directions.
- R7: In resolutions 010, 011, 100, 101, 110 and 111 the magnitudes are as follows, with angle = index × 360/128 degrees:
  - winding 1 magnitude is round(100·|cos(angle)|);
  - winding 2 magnitude is round(100·|sin(angle)|);
  - a polarity bit is 1 when its value is negative, and 0 whenever its magnitude is 0.
- R8: In resolutions 000 and 001 each winding magnitude is 100 when the R7 magnitude would be nonzero and 0 otherwise. Polarity follows the rule of R7.
- R9: While the translator reset input is 0, the index is held at 16 and the latched resolution at 000, and step edges are ignored.
- R10: A home request held for one or more cycles sets the index to 16 and the latched resolution to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| step_in | input | 1 | Step pulse, asynchronous; rising edge advances |
| dir_in | input | 1 | Direction, 0 = increasing angle |
| mode_sel | input | 3 | Resolution select, sampled on step edge |
| hold_n | input | 1 | Active-low translator reset, forces home |
| home_req | input | 1 | Home request from protection logic |
| w1_mag | output | 7 | Winding 1 current magnitude, percent |
| w1_neg | output | 1 | Winding 1 polarity, 1 = negative |
| w2_mag | output | 7 | Winding 2 current magnitude, percent |
| w2_neg | output | 1 | Winding 2 polarity, 1 = negative |

## Verification
A sequence of steps walks all eight resolutions in both directions.
- Backward full steps from home cross index 0, and forward ones cross it again, so carry and borrow errors appear at the wrap.
- Fine forward and backward steps land on off-axis indices. There, swapping the sine and cosine fold, or getting a polarity wrong, changes the expected magnitudes.
- A resolution change with no step is made at a point where full-torque shaping would give a different output, which shows whether the select is truly latched.
- Long step-high holds, and step pulses during translator reset, separate edge detection from level sensing.
- A step after each return to home shows that the home index and the latched resolution were both restored.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

  localparam int unsigned POS_W    = 7;
  localparam int unsigned QTR_W    = 5;
  localparam int unsigned MAG_W    = 7;
  localparam int unsigned CYCLE    = 1 << POS_W;
  localparam logic [POS_W-1:0] HOME_POS   = POS_W'(CYCLE / 8);
  localparam logic [POS_W-1:0] QUARTER    = POS_W'(CYCLE / 4);
  localparam logic [MAG_W-1:0] FULL_SCALE = MAG_W'(100);

  typedef enum logic [2:0] {
    RES_FULL_T   = 3'b000,
    RES_HALF_T   = 3'b001,
    RES_SIXTEEN  = 3'b010,
    RES_THIRTY2  = 3'b011,
    RES_FULL_S   = 3'b100,
    RES_HALF_S   = 3'b101,
    RES_QUARTER  = 3'b110,
    RES_EIGHTH   = 3'b111
  } res_mode_e;

  // log2 of the index stride for each resolution
  function automatic logic [2:0] stride_shift(input logic [2:0] m);
    logic [2:0] s;
    case (m)
      3'b000, 3'b100: s = 3'd5;
      3'b001, 3'b101: s = 3'd4;
      3'b110:         s = 3'd3;
      3'b111:         s = 3'd2;
      3'b010:         s = 3'd1;
      default:        s = 3'd0;
    endcase
    return s;
  endfunction

  function automatic logic is_full_torque(input logic [2:0] m);
    return (m[2:1] == 2'b00);
  endfunction

endpackage

// File: rtl/ustep_step_sync.sv
module ustep_step_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic adv_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], step_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
    end
  end

  assign adv_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/ustep_index_ctrl.sv
module ustep_index_ctrl
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             hold_n,
  input  logic             home_req,
  input  logic [2:0]       mode_in,
  input  logic             dir_in,
  output logic [POS_W-1:0] pos_q,
  output res_mode_e        mode_q
);
  logic             force_home;
  logic             load_en;
  logic [POS_W-1:0] stride;
  logic [POS_W-1:0] pos_d;
  res_mode_e        mode_d;

  assign force_home = ~hold_n | home_req;
  assign load_en    = force_home | adv;

  always_comb begin
    stride = POS_W'(1) << stride_shift(mode_in);
    pos_d  = pos_q;
    mode_d = mode_q;
    if (force_home) begin
      pos_d  = HOME_POS;
      mode_d = RES_FULL_T;
    end else if (adv) begin
      mode_d = res_mode_e'(mode_in);
      pos_d  = dir_in ? (pos_q - stride) : (pos_q + stride);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= HOME_POS;
      mode_q <= RES_FULL_T;
    end else if (load_en) begin
      pos_q  <= pos_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/ustep_quarter_lut.sv
module ustep_quarter_lut
  import ustep_pkg::*;
(
  input  logic [QTR_W:0]   ang,
  output logic [MAG_W-1:0] mag
);
  // round(100*sin(ang*90/32 degrees)), ang in 0..32
  always_comb begin
    case (ang)
      6'd0:  mag = 7'd0;
      6'd1:  mag = 7'd5;
      6'd2:  mag = 7'd10;
      6'd3:  mag = 7'd15;
      6'd4:  mag = 7'd20;
      6'd5:  mag = 7'd24;
      6'd6:  mag = 7'd29;
      6'd7:  mag = 7'd34;
      6'd8:  mag = 7'd38;
      6'd9:  mag = 7'd43;
      6'd10: mag = 7'd47;
      6'd11: mag = 7'd51;
      6'd12: mag = 7'd56;
      6'd13: mag = 7'd60;
      6'd14: mag = 7'd63;
      6'd15: mag = 7'd67;
      6'd16: mag = 7'd71;
      6'd17: mag = 7'd74;
      6'd18: mag = 7'd77;
      6'd19: mag = 7'd80;
      6'd20: mag = 7'd83;
      6'd21: mag = 7'd86;
      6'd22: mag = 7'd88;
      6'd23: mag = 7'd90;
      6'd24: mag = 7'd92;
      6'd25: mag = 7'd94;
      6'd26: mag = 7'd96;
      6'd27: mag = 7'd97;
      6'd28: mag = 7'd98;
      6'd29: mag = 7'd99;
      6'd30: mag = 7'd100;
      6'd31: mag = 7'd100;
      6'd32: mag = 7'd100;
      default: mag = 7'd0;
    endcase
  end

endmodule

// File: rtl/ustep_phase_map.sv
module ustep_phase_map
  import ustep_pkg::*;
(
  input  logic [POS_W-1:0]            pos,
  input  logic                        full_torque,
  output logic [1:0][MAG_W-1:0]       mag_o,
  output logic [1:0]                  neg_o
);
  // winding index 0 = cosine (winding 1), 1 = sine (winding 2)
  for (genvar w = 0; w < 2; w++) begin : g_wind
    localparam logic [POS_W-1:0] SHIFT = (w == 0) ? QUARTER : '0;

    logic [POS_W-1:0] rot;
    logic [QTR_W-1:0] off;
    logic [QTR_W:0]   fold;
    logic [MAG_W-1:0] raw;
    logic [MAG_W-1:0] shaped;

    always_comb begin
      rot  = pos + SHIFT;
      off  = rot[QTR_W-1:0];
      fold = rot[QTR_W] ? ((QTR_W+1)'(1 << QTR_W) - {1'b0, off}) : {1'b0, off};
    end

    ustep_quarter_lut u_lut (
      .ang (fold),
      .mag (raw)
    );

    always_comb begin
      if (full_torque) begin
        shaped = (raw != '0) ? FULL_SCALE : '0;
      end else begin
        shaped = raw;
      end
      mag_o[w] = shaped;
      neg_o[w] = rot[POS_W-1] & (shaped != '0);
    end
  end

endmodule

// File: rtl/ustep_translator.sv
module ustep_translator
  import ustep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [2:0]       mode_sel,
  input  logic             hold_n,
  input  logic             home_req,
  output logic [MAG_W-1:0] w1_mag,
  output logic             w1_neg,
  output logic [MAG_W-1:0] w2_mag,
  output logic             w2_neg
);
  logic                  adv_pulse;
  logic [POS_W-1:0]      pos_q;
  res_mode_e             mode_q;
  logic [1:0][MAG_W-1:0] mag_w;
  logic [1:0]            neg_w;

  ustep_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_in (step_in),
    .adv_o   (adv_pulse)
  );

  ustep_index_ctrl u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_pulse),
    .hold_n   (hold_n),
    .home_req (home_req),
    .mode_in  (mode_sel),
    .dir_in   (dir_in),
    .pos_q    (pos_q),
    .mode_q   (mode_q)
  );

  ustep_phase_map u_map (
    .pos         (pos_q),
    .full_torque (is_full_torque(mode_q)),
    .mag_o       (mag_w),
    .neg_o       (neg_w)
  );

  assign w1_mag = mag_w[0];
  assign w1_neg = neg_w[0];
  assign w2_mag = mag_w[1];
  assign w2_neg = neg_w[1];

endmodule

// File: rtl/ustep_checker.sv
module ustep_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_n,
  input logic       home_req,
  input logic       adv,
  input logic [6:0] pos_q,
  input logic [2:0] mode_q,
  input logic [6:0] w1_mag,
  input logic       w1_neg,
  input logic [6:0] w2_mag,
  input logic       w2_neg
);
  logic [6:0] pos_prev;
  logic [6:0] diff_fwd;
  logic [6:0] diff_bwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_prev <= 7'd16;
    else        pos_prev <= pos_q;
  end

  assign diff_fwd = pos_q - pos_prev;
  assign diff_bwd = pos_prev - pos_q;

  assert_adv_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv);

  assert_stride_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hold_n && !home_req) |=>
      (($countones(diff_fwd) == 1) || ($countones(diff_bwd) == 1)));

  assert_no_edge_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && hold_n && !home_req) |=> ($stable(pos_q) && $stable(mode_q)));

  assert_hold_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> (pos_q == 7'd16 && mode_q == 3'b000));

  assert_req_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
    home_req |=> (pos_q == 7'd16 && mode_q == 3'b000));

  assert_mag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w1_mag <= 7'd100) && (w2_mag <= 7'd100));

  assert_zero_pol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1_mag == 7'd0) |-> !w1_neg) and ((w2_mag == 7'd0) |-> !w2_neg));

  assert_full_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:1] == 2'b00) |->
      ((w1_mag == 7'd0 || w1_mag == 7'd100) && (w2_mag == 7'd0 || w2_mag == 7'd100)));

endmodule

bind ustep_translator ustep_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_n   (hold_n),
  .home_req (home_req),
  .adv      (adv_pulse),
  .pos_q    (pos_q),
  .mode_q   (mode_q),
  .w1_mag   (w1_mag),
  .w1_neg   (w1_neg),
  .w2_mag   (w2_mag),
  .w2_neg   (w2_neg)
);

// File: tb/tb_ustep_translator.sv
module tb_ustep_translator;

  logic       clk;
  logic       rst_n;
  logic       step_in;
  logic       dir_in;
  logic [2:0] mode_sel;
  logic       hold_n;
  logic       home_req;
  logic [6:0] w1_mag;
  logic       w1_neg;
  logic [6:0] w2_mag;
  logic       w2_neg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int         m_idx;
  logic [2:0] m_mode;

  ustep_translator dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_in  (step_in),
    .dir_in   (dir_in),
    .mode_sel (mode_sel),
    .hold_n   (hold_n),
    .home_req (home_req),
    .w1_mag   (w1_mag),
    .w1_neg   (w1_neg),
    .w2_mag   (w2_mag),
    .w2_neg   (w2_neg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {dir, mode} per vector
  localparam int NVEC = 25;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1000, 4'b0000, 4'b0011, 4'b0011, 4'b0010, 4'b0111, 4'b0110, 4'b0001,
    4'b0101, 4'b0100, 4'b1011, 4'b1010, 4'b1111, 4'b1110, 4'b1101, 4'b1100,
    4'b1001, 4'b1011, 4'b1011, 4'b1111, 4'b1110, 4'b1011, 4'b1010, 4'b1011,
    4'b0011
  };

  function automatic int stride_of(input logic [2:0] m);
    case (m)
      3'b000, 3'b100: return 32;
      3'b001, 3'b101: return 16;
      3'b110:         return 8;
      3'b111:         return 4;
      3'b010:         return 2;
      default:        return 1;
    endcase
  endfunction

  function automatic logic [15:0] expect_out(input int idx, input logic [2:0] m);
    real ang, c, s;
    int  cm, sm;
    logic cn, sn;
    ang = 2.0 * 3.14159265358979 * idx / 128.0;
    c = $cos(ang);
    s = $sin(ang);
    cm = $rtoi(((c < 0.0) ? -c : c) * 100.0 + 0.5);
    sm = $rtoi(((s < 0.0) ? -s : s) * 100.0 + 0.5);
    if (m[2:1] == 2'b00) begin
      cm = (cm != 0) ? 100 : 0;
      sm = (sm != 0) ? 100 : 0;
    end
    cn = (c < 0.0) && (cm != 0);
    sn = (s < 0.0) && (sm != 0);
    return {cn, 7'(cm), sn, 7'(sm)};
  endfunction

  task automatic check_out(input string tag, input logic [15:0] exp_v);
    logic [15:0] act;
    act = {w1_neg, w1_mag, w2_neg, w2_mag};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual w1=%0s%0d w2=%0s%0d expected w1=%0s%0d w2=%0s%0d", tag,
               act[15] ? "-" : "+", act[14:8], act[7] ? "-" : "+", act[6:0],
               exp_v[15] ? "-" : "+", exp_v[14:8], exp_v[7] ? "-" : "+", exp_v[6:0]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // step with model update when counts is set
  task automatic do_step(input logic [2:0] m, input logic d, input bit counts);
    mode_sel = m;
    dir_in   = d;
    idle(2);
    step_in = 1'b1;
    idle(5);
    step_in = 1'b0;
    idle(5);
    if (counts) begin
      m_mode = m;
      m_idx  = d ? ((m_idx - stride_of(m) + 128) % 128) : ((m_idx + stride_of(m)) % 128);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    step_in  = 1'b0;
    dir_in   = 1'b0;
    mode_sel = 3'b000;
    hold_n   = 1'b1;
    home_req = 1'b0;
    m_idx    = 16;
    m_mode   = 3'b000;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state is home, full-torque shaping
    check_out("R1 reset home", expect_out(16, 3'b000));

    // R2 R4 R6 R7 R8: walk of resolutions and directions, including wraps
    for (int v = 0; v < NVEC; v++) begin
      do_step(VEC[v][2:0], VEC[v][3], 1'b1);
      check_out($sformatf("R2 R4 R6 R7 R8 vector %0d idx %0d", v, m_idx),
                expect_out(m_idx, m_mode));
    end

    // R5: select and direction change with no step edge
    do_step(3'b011, 1'b0, 1'b1);
    mode_sel = 3'b000;
    dir_in   = 1'b1;
    idle(8);
    check_out("R5 no edge no change", expect_out(m_idx, m_mode));
    do_step(3'b000, 1'b1, 1'b1);
    check_out("R5 new select at edge", expect_out(m_idx, m_mode));

    // R3: step held high advances only once
    mode_sel = 3'b011;
    dir_in   = 1'b0;
    idle(2);
    step_in = 1'b1;
    idle(30);
    m_idx  = (m_idx + 1) % 128;
    m_mode = 3'b011;
    check_out("R3 held high single move", expect_out(m_idx, m_mode));
    step_in = 1'b0;
    idle(5);
    check_out("R3 falling edge no move", expect_out(m_idx, m_mode));

    // R9: translator reset ignores steps and holds home
    hold_n = 1'b0;
    idle(2);
    for (int k = 0; k < 3; k++) do_step(3'b011, 1'b0, 1'b0);
    m_idx  = 16;
    m_mode = 3'b000;
    check_out("R9 held home", expect_out(m_idx, m_mode));
    hold_n = 1'b1;
    idle(2);
    do_step(3'b011, 1'b0, 1'b1);
    check_out("R9 step from home", expect_out(m_idx, m_mode));

    // R10: home request
    do_step(3'b110, 1'b0, 1'b1);
    home_req = 1'b1;
    idle(1);
    home_req = 1'b0;
    idle(2);
    m_idx  = 16;
    m_mode = 3'b000;
    check_out("R10 home request", expect_out(m_idx, m_mode));
    do_step(3'b010, 1'b1, 1'b1);
    check_out("R10 step from home", expect_out(m_idx, m_mode));

    // R1: system reset mid-run
    do_step(3'b111, 1'b0, 1'b1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    m_idx  = 16;
    m_mode = 3'b000;
    check_out("R1 reset mid-run", expect_out(m_idx, m_mode));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule